// File: doc/BRIEF.md
# Per-Sector Write-Protection Controller

This block holds the write-protection state of every sector of a flash array. Each sector has two protection bits. The first is a volatile bit that software can set and clear at any time. The second is a persistent bit, modelled here as a register with a reset value. A sector counts as protected when either of its two bits is set. A single global lock freezes all persistent bits while it is set; the volatile bits stay writable under the lock.

The lock can be set at any time. It clears at power-up (reset). Once a one-way password mode is entered, the lock can also be cleared at run time, but only by presenting a 64-bit key that equals the stored key. Every key check, whether the key matches or not, holds the block busy for a fixed number of cycles, and the block refuses all commands during that window. A one-way hide bit stops the stored key from being read back or rewritten.

Commands arrive as a one-cycle strobe carrying an opcode, a sector index and a key. Every outcome is registered and appears in the cycle after the strobe: a rejection pulse, a response pulse with its data, and the updated per-sector protection vector.

Top module: `sect_prot_ctrl`

## Requirements
- R1: After reset, all volatile bits are clear, the persistent bits hold `PER_INIT` (default all clear), and the lock, password mode and hide bit are clear. In that state `prot_o` is zero and `busy_o`, `rejected_o` and `resp_valid_o` are low.
- R2: Opcode 1 sets the volatile bit of the addressed sector and opcode 2 clears it. The change shows on `prot_o` in the next cycle, whether or not the lock is set.
- R3: `prot_o[i]` is high exactly when the persistent bit or the volatile bit of sector i is set.
- R4: While the lock is set, opcode 3 (set one persistent bit) and opcode 4 (clear all persistent bits) are rejected and leave every persistent bit unchanged. Opcode 5 sets the lock.
- R5: With the lock clear, opcode 3 sets the persistent bit of the addressed sector and opcode 4 clears the persistent bits of all sectors.
- R6: Opcode 6 (key unlock) is rejected outside password mode, and the lock is left as it was. In password mode (entered by opcode 10, which cannot be undone until reset) the lock clears only if the key supplied equals the stored key. A mismatch changes nothing.
- R7: An accepted opcode 6 raises `busy_o` in the next cycle and holds it for exactly `CHECK_CYCLES` cycles. On a match, the lock clears on the same edge that drops `busy_o`.
- R8: Any command that arrives while `busy_o` is high is rejected and has no effect on any state.
- R9: Opcode 9 returns the stored key on `resp_data_o`, and opcode 8 replaces it with `key_i`. The stored key resets to `KEY_INIT` (default all ones). After opcode 11 sets the hide bit, opcodes 8 and 9 are rejected, give no response and leave the key unchanged.
- R10: Opcode 7 queries the persistent bit of a sector. `resp_valid_o` pulses, and `resp_data_o` reads 00h when the bit is set and 01h when it is clear, with all upper bits zero. The response pulse and the rejection pulse are never high together.
- R11: A sector index of `NUM_SECTORS` or more, used with opcode 1, 2, 3 or 7, is rejected. Opcodes 12 to 15 are rejected. Opcode 0 does nothing and is not rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Opcode |
| sector_i | input | SECT_W | Sector index |
| key_i | input | KEY_W | Key for unlock or key program |
| prot_o | output | NUM_SECTORS | Per-sector protected flag |
| busy_o | output | 1 | Key check in progress |
| rejected_o | output | 1 | Previous command rejected |
| resp_valid_o | output | 1 | Response pulse for query or key read |
| resp_data_o | output | KEY_W | Response data |

## Verification
Volatile and persistent bits are driven on the same sector and on separate sectors. This separates an OR of the two bits from logic that follows only one of them. Persistent-bit commands are issued both with the lock set and with it clear, which exposes a lock that gates the wrong bits or gates nothing. Key unlocks are tried outside password mode, with a wrong key and with the right key, and stray commands are issued in the middle of a check. Together these show whether the match, the mode and the busy window each decide the outcome. Reads and writes of the key before and after hiding, followed by an unlock with the old key, show that a hidden key can be neither read back nor replaced.

// File: rtl/sect_prot_pkg.sv
`timescale 1ns/1ps
package sect_prot_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_DYN_SET    = 4'd1,
    OP_DYN_CLR    = 4'd2,
    OP_PER_PROG   = 4'd3,
    OP_PER_ERASE  = 4'd4,
    OP_LOCK_SET   = 4'd5,
    OP_KEY_UNLOCK = 4'd6,
    OP_PER_QUERY  = 4'd7,
    OP_KEY_PROG   = 4'd8,
    OP_KEY_READ   = 4'd9,
    OP_KEY_MODE   = 4'd10,
    OP_KEY_HIDE   = 4'd11
  } prot_op_e;

  typedef struct packed {
    logic dyn_set;
    logic dyn_clr;
    logic per_prog;
    logic per_erase;
    logic lock_set;
    logic key_check;
    logic per_query;
    logic key_prog;
    logic key_read;
    logic key_mode;
    logic key_hide;
  } prot_act_t;

  localparam logic [7:0] QUERY_PER_SET = 8'h00;
  localparam logic [7:0] QUERY_PER_CLR = 8'h01;

endpackage

// File: rtl/prot_cmd_decode.sv
`timescale 1ns/1ps
module prot_cmd_decode
  import sect_prot_pkg::*;
#(
  parameter int NUM_SECTORS = 46,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic              busy_i,
  input  logic              locked_i,
  input  logic              key_mode_i,
  input  logic              key_hidden_i,
  output prot_act_t         act_o,
  output logic              reject_o
);

  localparam logic [SECT_W:0] SECT_LIMIT = (SECT_W+1)'(NUM_SECTORS);

  logic sect_ok;
  assign sect_ok = {1'b0, sector_i} < SECT_LIMIT;

  always_comb begin
    act_o    = '0;
    reject_o = 1'b0;
    if (cmd_valid_i) begin
      if (busy_i) begin
        reject_o = 1'b1;
      end else begin
        case (cmd_op_i)
          OP_NOP: ;
          OP_DYN_SET:    if (sect_ok) act_o.dyn_set = 1'b1; else reject_o = 1'b1;
          OP_DYN_CLR:    if (sect_ok) act_o.dyn_clr = 1'b1; else reject_o = 1'b1;
          OP_PER_PROG:   if (sect_ok && !locked_i) act_o.per_prog = 1'b1; else reject_o = 1'b1;
          OP_PER_ERASE:  if (!locked_i) act_o.per_erase = 1'b1; else reject_o = 1'b1;
          OP_LOCK_SET:   act_o.lock_set = 1'b1;
          OP_KEY_UNLOCK: if (key_mode_i) act_o.key_check = 1'b1; else reject_o = 1'b1;
          OP_PER_QUERY:  if (sect_ok) act_o.per_query = 1'b1; else reject_o = 1'b1;
          OP_KEY_PROG:   if (!key_hidden_i) act_o.key_prog = 1'b1; else reject_o = 1'b1;
          OP_KEY_READ:   if (!key_hidden_i) act_o.key_read = 1'b1; else reject_o = 1'b1;
          OP_KEY_MODE:   act_o.key_mode = 1'b1;
          OP_KEY_HIDE:   act_o.key_hide = 1'b1;
          default:       reject_o = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/prot_bit_array.sv
`timescale 1ns/1ps
module prot_bit_array #(
  parameter int                     NUM_SECTORS = 46,
  parameter int                     SECT_W      = $clog2(NUM_SECTORS),
  parameter logic [NUM_SECTORS-1:0] PER_INIT    = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SECT_W-1:0]      sector_i,
  input  logic                   dyn_set_i,
  input  logic                   dyn_clr_i,
  input  logic                   per_prog_i,
  input  logic                   per_erase_i,
  output logic [NUM_SECTORS-1:0] per_o,
  output logic [NUM_SECTORS-1:0] prot_o
);

  logic [NUM_SECTORS-1:0] dyn_q;
  logic [NUM_SECTORS-1:0] per_q;

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sect
    logic hit;
    assign hit = (sector_i == SECT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dyn_q[g] <= 1'b0;
      end else if (hit && dyn_set_i) begin
        dyn_q[g] <= 1'b1;
      end else if (hit && dyn_clr_i) begin
        dyn_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_q[g] <= PER_INIT[g];
      end else if (per_erase_i) begin
        per_q[g] <= 1'b0;
      end else if (hit && per_prog_i) begin
        per_q[g] <= 1'b1;
      end
    end

    assign prot_o[g] = per_q[g] | dyn_q[g];
  end

  assign per_o = per_q;

endmodule

// File: rtl/prot_key_unit.sv
`timescale 1ns/1ps
module prot_key_unit #(
  parameter int               KEY_W        = 64,
  parameter int               CHECK_CYCLES = 100,
  parameter logic [KEY_W-1:0] KEY_INIT     = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic             lock_set_i,
  input  logic             key_check_i,
  input  logic             key_prog_i,
  input  logic             key_mode_i,
  input  logic             key_hide_i,
  output logic             locked_o,
  output logic             busy_o,
  output logic             key_mode_o,
  output logic             key_hidden_o,
  output logic [KEY_W-1:0] key_o
);

  localparam int CNT_W = $clog2(CHECK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CHECK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             match_q;
  logic             lock_q;
  logic             mode_q;
  logic             hide_q;
  logic [KEY_W-1:0] key_q;
  logic             check_done;

  assign check_done = (cnt_q == CNT_LAST);

  // check window: compare at accept, apply result when window ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else if (key_check_i) begin
      cnt_q   <= CNT_LOAD;
      match_q <= (key_i == key_q);
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - CNT_LAST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
    end else if (lock_set_i) begin
      lock_q <= 1'b1;
    end else if (check_done && match_q) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      hide_q <= 1'b0;
      key_q  <= KEY_INIT;
    end else begin
      if (key_mode_i) mode_q <= 1'b1;
      if (key_hide_i) hide_q <= 1'b1;
      if (key_prog_i) key_q  <= key_i;
    end
  end

  assign locked_o     = lock_q;
  assign busy_o       = (cnt_q != '0);
  assign key_mode_o   = mode_q;
  assign key_hidden_o = hide_q;
  assign key_o        = key_q;

endmodule

// File: rtl/sect_prot_ctrl.sv
`timescale 1ns/1ps
module sect_prot_ctrl
  import sect_prot_pkg::*;
#(
  parameter int                     NUM_SECTORS  = 46,
  parameter int                     SECT_W       = $clog2(NUM_SECTORS),
  parameter int                     KEY_W        = 64,
  parameter int                     CHECK_CYCLES = 100,
  parameter logic [NUM_SECTORS-1:0] PER_INIT     = '0,
  parameter logic [KEY_W-1:0]       KEY_INIT     = '1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [3:0]             cmd_op_i,
  input  logic [SECT_W-1:0]      sector_i,
  input  logic [KEY_W-1:0]       key_i,
  output logic [NUM_SECTORS-1:0] prot_o,
  output logic                   busy_o,
  output logic                   rejected_o,
  output logic                   resp_valid_o,
  output logic [KEY_W-1:0]       resp_data_o
);

  prot_act_t              act;
  logic                   reject;
  logic                   lock_q;
  logic                   key_mode_q;
  logic                   key_hidden_q;
  logic [KEY_W-1:0]       key_q;
  logic [NUM_SECTORS-1:0] per_q;
  logic                   rejected_q;
  logic                   resp_valid_q;
  logic [KEY_W-1:0]       resp_data_q;

  prot_cmd_decode #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W)
  ) u_decode (
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .sector_i     (sector_i),
    .busy_i       (busy_o),
    .locked_i     (lock_q),
    .key_mode_i   (key_mode_q),
    .key_hidden_i (key_hidden_q),
    .act_o        (act),
    .reject_o     (reject)
  );

  prot_bit_array #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W),
    .PER_INIT    (PER_INIT)
  ) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sector_i    (sector_i),
    .dyn_set_i   (act.dyn_set),
    .dyn_clr_i   (act.dyn_clr),
    .per_prog_i  (act.per_prog),
    .per_erase_i (act.per_erase),
    .per_o       (per_q),
    .prot_o      (prot_o)
  );

  prot_key_unit #(
    .KEY_W        (KEY_W),
    .CHECK_CYCLES (CHECK_CYCLES),
    .KEY_INIT     (KEY_INIT)
  ) u_key (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_i        (key_i),
    .lock_set_i   (act.lock_set),
    .key_check_i  (act.key_check),
    .key_prog_i   (act.key_prog),
    .key_mode_i   (act.key_mode),
    .key_hide_i   (act.key_hide),
    .locked_o     (lock_q),
    .busy_o       (busy_o),
    .key_mode_o   (key_mode_q),
    .key_hidden_o (key_hidden_q),
    .key_o        (key_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rejected_q   <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      rejected_q   <= reject;
      resp_valid_q <= act.per_query | act.key_read;
      if (act.per_query) begin
        resp_data_q <= {{(KEY_W-8){1'b0}},
                        (per_q[sector_i] ? QUERY_PER_SET : QUERY_PER_CLR)};
      end else if (act.key_read) begin
        resp_data_q <= key_q;
      end else begin
        resp_data_q <= '0;
      end
    end
  end

  assign rejected_o   = rejected_q;
  assign resp_valid_o = resp_valid_q;
  assign resp_data_o  = resp_data_q;

endmodule

// File: rtl/sect_prot_ctrl_chk.sv
`timescale 1ns/1ps
module sect_prot_ctrl_chk
  import sect_prot_pkg::*;
#(
  parameter int NUM_SECTORS = 46,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cmd_valid_i,
  input logic [3:0]             cmd_op_i,
  input logic [SECT_W-1:0]      sector_i,
  input logic [NUM_SECTORS-1:0] prot_o,
  input logic                   busy_o,
  input logic                   rejected_o,
  input logic                   resp_valid_o,
  input logic [NUM_SECTORS-1:0] per_q,
  input logic                   lock_q,
  input logic                   key_hidden_q
);

  localparam logic [SECT_W:0] SECT_LIMIT = (SECT_W+1)'(NUM_SECTORS);

  logic sect_ok;
  assign sect_ok = {1'b0, sector_i} < SECT_LIMIT;

  p_dyn_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && sect_ok && cmd_op_i == OP_DYN_SET)
      |=> prot_o[$past(sector_i)]);

  p_per_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q) |-> $stable(per_q));

  p_unlock_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $fell(busy_o));

  p_busy_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> rejected_o);

  p_hidden_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && key_hidden_q && cmd_op_i == OP_KEY_READ)
      |=> (rejected_o && !resp_valid_o));

  p_resp_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !rejected_o);

  p_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && !sect_ok && cmd_op_i == OP_DYN_SET) |=> rejected_o);

endmodule

bind sect_prot_ctrl sect_prot_ctrl_chk #(
  .NUM_SECTORS (NUM_SECTORS),
  .SECT_W      (SECT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .sector_i     (sector_i),
  .prot_o       (prot_o),
  .busy_o       (busy_o),
  .rejected_o   (rejected_o),
  .resp_valid_o (resp_valid_o),
  .per_q        (per_q),
  .lock_q       (lock_q),
  .key_hidden_q (key_hidden_q)
);

// File: tb/sect_prot_ctrl_bench.sv
`timescale 1ns/1ps
module sect_prot_ctrl_bench;

  localparam int NS = 46;
  localparam int SW = 6;
  localparam int KW = 64;
  localparam int CC = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [SW-1:0] sector = '0;
  logic [KW-1:0] key = '0;
  logic [NS-1:0] prot_o;
  logic          busy_o, rejected_o, resp_valid_o;
  logic [KW-1:0] resp_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sect_prot_ctrl u_sect_prot_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .sector_i     (sector),
    .key_i        (key),
    .prot_o       (prot_o),
    .busy_o       (busy_o),
    .rejected_o   (rejected_o),
    .resp_valid_o (resp_valid_o),
    .resp_data_o  (resp_data_o)
  );

  // behavioural reference model
  bit            m_dyn [NS];
  bit            m_per [NS];
  bit            m_lock, m_mode, m_hide, m_match, m_rej, m_rv;
  logic [KW-1:0] m_key, m_rd;
  int            m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_dyn[i]) begin m_dyn[i] = 0; m_per[i] = 0; end
      m_lock = 0; m_mode = 0; m_hide = 0; m_match = 0;
      m_rej = 0; m_rv = 0; m_rd = '0; m_key = '1; m_cnt = 0;
    end else begin
      bit was_busy;
      int s;
      was_busy = (m_cnt > 0);
      s = int'(sector);
      m_rej = 0; m_rv = 0; m_rd = '0;
      if (was_busy) begin
        if (m_cnt == 1 && m_match) m_lock = 0;
        m_cnt--;
      end
      if (cmd_valid) begin
        if (was_busy) m_rej = 1;
        else begin
          case (int'(cmd_op))
            0: ;
            1: if (s < NS) m_dyn[s] = 1; else m_rej = 1;
            2: if (s < NS) m_dyn[s] = 0; else m_rej = 1;
            3: if (s < NS && !m_lock) m_per[s] = 1; else m_rej = 1;
            4: if (!m_lock) foreach (m_per[i]) m_per[i] = 0; else m_rej = 1;
            5: m_lock = 1;
            6: if (m_mode) begin m_cnt = CC; m_match = (key == m_key); end else m_rej = 1;
            7: if (s < NS) begin m_rv = 1; m_rd = m_per[s] ? 64'h0 : 64'h1; end else m_rej = 1;
            8: if (!m_hide) m_key = key; else m_rej = 1;
            9: if (!m_hide) begin m_rv = 1; m_rd = m_key; end else m_rej = 1;
            10: m_mode = 1;
            11: m_hide = 1;
            default: m_rej = 1;
          endcase
        end
      end
    end
  end

  function automatic logic [NS-1:0] m_prot();
    logic [NS-1:0] v;
    for (int i = 0; i < NS; i++) v[i] = m_dyn[i] | m_per[i];
    return v;
  endfunction

  task automatic chk(string tag, logic [KW-1:0] act, logic [KW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 prot_o vs model", KW'(prot_o), KW'(m_prot()));
      chk("R7 busy_o vs model", KW'(busy_o), KW'(m_cnt > 0));
      chk("R8 R11 rejected_o vs model", KW'(rejected_o), KW'(m_rej));
      chk("R10 resp_valid_o vs model", KW'(resp_valid_o), KW'(m_rv));
      chk("R9 R10 resp_data_o vs model", resp_data_o, m_rd);
    end
  end

  task automatic issue(input int op, input int sec, input logic [KW-1:0] k);
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    sector    = SW'(sec);
    key       = k;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin
      @(negedge clk);
      n++;
    end
  endtask

  localparam logic [KW-1:0] K1 = 64'h0123_4567_89ab_cdef;
  localparam logic [KW-1:0] K2 = 64'hfeed_0000_beef_1111;

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 prot_o after reset", KW'(prot_o), '0);
    chk("R1 busy_o after reset", KW'(busy_o), '0);
    chk("R1 rejected_o after reset", KW'(rejected_o), '0);

    issue(1, 5, '0);
    chk("R2 dyn set sector 5", KW'(prot_o[5]), 1);
    issue(2, 5, '0);
    chk("R2 dyn clear sector 5", KW'(prot_o[5]), 0);

    issue(3, 7, '0);
    chk("R5 per prog sector 7", KW'(prot_o[7]), 1);
    issue(7, 7, '0);
    chk("R10 query set bit", resp_data_o, 64'h0);
    issue(7, 8, '0);
    chk("R10 query clear bit", resp_data_o, 64'h1);
    chk("R10 query valid", KW'(resp_valid_o), 1);

    issue(3, 3, '0);
    issue(1, 3, '0);
    issue(2, 3, '0);
    chk("R3 per alone keeps sector 3 protected", KW'(prot_o[3]), 1);
    issue(4, 0, '0);
    chk("R5 erase all clears persistent", KW'(prot_o), '0);

    issue(3, 9, '0);
    issue(5, 0, '0);
    issue(3, 12, '0);
    chk("R4 prog under lock rejected", KW'(rejected_o), 1);
    chk("R4 prog under lock no effect", KW'(prot_o[12]), 0);
    issue(4, 0, '0);
    chk("R4 erase under lock no effect", KW'(prot_o[9]), 1);
    issue(1, 10, '0);
    chk("R2 dyn set works under lock", KW'(prot_o[10]), 1);

    issue(6, 0, '1);
    chk("R6 unlock outside key mode rejected", KW'(rejected_o), 1);
    chk("R6 no busy outside key mode", KW'(busy_o), 0);

    issue(9, 0, '0);
    chk("R9 read initial key", resp_data_o, '1);
    issue(8, 0, K1);
    issue(9, 0, '0);
    chk("R9 read programmed key", resp_data_o, K1);

    issue(10, 0, '0);
    issue(6, 0, K2);
    chk("R7 busy after wrong key", KW'(busy_o), 1);
    issue(1, 20, '0);
    chk("R8 command during check rejected", KW'(rejected_o), 1);
    chk("R8 command during check no effect", KW'(prot_o[20]), 0);
    wait_idle(n);
    issue(3, 12, '0);
    chk("R6 wrong key keeps lock", KW'(rejected_o), 1);

    issue(6, 0, K1);
    wait_idle(n);
    chk("R7 check window length", KW'(n), KW'(CC));
    issue(3, 12, '0);
    chk("R6 right key clears lock", KW'(prot_o[12]), 1);

    issue(11, 0, '0);
    issue(9, 0, '0);
    chk("R9 hidden read rejected", KW'(rejected_o), 1);
    chk("R9 hidden read gives no response", KW'(resp_valid_o), 0);
    issue(8, 0, K2);
    chk("R9 hidden key prog rejected", KW'(rejected_o), 1);
    issue(5, 0, '0);
    issue(6, 0, K1);
    wait_idle(n);
    issue(3, 13, '0);
    chk("R9 old key still unlocks", KW'(prot_o[13]), 1);

    issue(1, 46, '0);
    chk("R11 sector 46 rejected", KW'(rejected_o), 1);
    issue(7, 63, '0);
    chk("R11 query sector 63 rejected", KW'(rejected_o), 1);
    issue(15, 0, '0);
    chk("R11 opcode 15 rejected", KW'(rejected_o), 1);
    issue(0, 0, '0);
    chk("R11 opcode 0 not rejected", KW'(rejected_o), 0);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 prot_o cleared by second reset", KW'(prot_o), '0);
    issue(3, 1, '0);
    chk("R1 lock clear after reset", KW'(prot_o[1]), 1);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule